// File: doc/BRIEF.md
# Shared Instruction/Data Test Memory

This block is the memory model that sits beside a small pipelined core in a test harness. It holds one array of 32-bit words and serves it through two ports. The fetch port is read-only. The data port performs either a load or a store. Both ports see the same contents, so code that the core stores through the data port is fetched back unchanged. Reads on both ports are combinational: the response appears in the same cycle as the request. A store is committed on the next rising clock edge. Addresses are byte addresses. The two low bits are dropped. The bits above the array depth are also dropped, so accesses wrap around the array. `DEPTH` must be a power of two.

A preload port lets the harness fill the array before the core runs. A separate mailbox register receives a completion code from the core. When that code is non-zero, a sticky completion flag is raised for the monitor. Reset clears only the mailbox and the flag. The array contents are kept.

Requests carry a valid qualifier only. Every valid request is accepted in the cycle it is presented. No request is ever stalled, so the block has no ready signal and applies no back-pressure. A requester never needs to hold a request for more than one cycle.

Top module: `shared_test_mem`

## Requirements
- R1: A word stored through the data port is returned by a fetch of the same word in any later cycle.
- R2: Address bits [1:0] are ignored on the fetch, data and preload ports. Bits [log2(DEPTH)+1:2] select the word.
- R3: Address bits above bit log2(DEPTH)+1 are ignored. For example, byte address (DEPTH+k)*4 reaches word k.
- R4: Read data is combinational. `fetch_data` shows the addressed word in the same cycle that `fetch_valid` is high, and is 0 when `fetch_valid` is low. `data_rdata` shows the addressed word during a load (`data_valid`=1, `data_wr`=0).
- R5: A store commits at the rising clock edge. A fetch of the same word in the same cycle as the store returns the old contents.
- R6: The array does not change when `data_valid` is low or `data_wr` is 0, unless the preload port writes.
- R7: After reset, `mbox_value` is 0 and `run_done` is 0. Reset leaves the array contents unchanged.
- R8: When `mbox_we` is high, `mbox_wdata` is loaded into the mailbox at the clock edge. `run_done` goes high in the same cycle that the mailbox first becomes non-zero.
- R9: Once `run_done` is high, it stays high until reset, even if 0 is later written to the mailbox.
- R10: `preload_we` writes `preload_wdata` at the edge. When a store is also valid in that cycle, the preload is dropped and only the store takes effect.
- R11: `data_rdata` is 0 whenever the data port is not performing a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for the mailbox and the completion flag |
| fetch_valid | input | 1 | Fetch request qualifier |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_data | output | 32 | Fetched word (combinational) |
| data_valid | input | 1 | Data request qualifier |
| data_wr | input | 1 | 0 = load, 1 = store |
| data_addr | input | 32 | Data byte address |
| data_wdata | input | 32 | Store data |
| data_rdata | output | 32 | Load data (combinational) |
| preload_we | input | 1 | Harness preload write strobe |
| preload_addr | input | 32 | Preload byte address |
| preload_wdata | input | 32 | Preload data |
| mbox_we | input | 1 | Mailbox write strobe |
| mbox_wdata | input | 32 | Mailbox write data |
| mbox_value | output | 32 | Current mailbox contents |
| run_done | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with `DEPTH` = 64. This keeps the array small and brings the wrap-around boundary within easy reach: byte address (64+k)*4 must alias word k. The small depth also leaves the low-bit aliasing, the same-cycle store/fetch collision and the store-over-preload conflict as cheap, direct vectors. The mailbox sequence writes zero, then a non-zero code, then zero again, and then resets. This shows that the flag rises with the mailbox, stays set, and is cleared only by reset, while the array survives the reset.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BYTE_SEL_W = 2;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/stm_index.sv
module stm_index #(
  parameter int unsigned IDX_W = 10
) (
  input  stm_pkg::word_t   byte_addr,
  output logic [IDX_W-1:0] word_idx
);
  // The low byte-select bits and every bit above the depth are dropped.
  assign word_idx = byte_addr[stm_pkg::BYTE_SEL_W +: IDX_W];
endmodule

// File: rtl/stm_wsel.sv
module stm_wsel #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             st_en,
  input  logic [IDX_W-1:0] st_idx,
  input  stm_pkg::word_t   st_data,
  input  logic             pl_en,
  input  logic [IDX_W-1:0] pl_idx,
  input  stm_pkg::word_t   pl_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output stm_pkg::word_t   wr_data
);
  // A core store outranks a harness preload in the same cycle.
  always_comb begin
    wr_en   = st_en | pl_en;
    wr_idx  = st_en ? st_idx  : pl_idx;
    wr_data = st_en ? st_data : pl_data;
  end
endmodule

// File: rtl/stm_array.sv
module stm_array #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  stm_pkg::word_t   wr_data,
  input  logic [IDX_W-1:0] rd_a_idx,
  output stm_pkg::word_t   rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output stm_pkg::word_t   rd_b_data
);
  stm_pkg::word_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_a_data = mem_q[rd_a_idx];
  assign rd_b_data = mem_q[rd_b_idx];

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> mem_q[$past(rd_a_idx)] == $past(rd_a_data)); // R6
endmodule

// File: rtl/stm_mailbox.sv
module stm_mailbox (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  stm_pkg::word_t wdata,
  output stm_pkg::word_t value,
  output logic           done
);
  stm_pkg::word_t box_q;
  logic           done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      box_q  <= '0;
      done_q <= 1'b0;
    end else if (we) begin
      box_q <= wdata;
      if (wdata != '0) done_q <= 1'b1;
    end
  end

  assign value = box_q;
  assign done  = done_q;

  AST_MBOX_CLEARED: assert property (@(posedge clk)
    !rst_n |=> (value == '0 && !done)); // R7
  AST_DONE_ON_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (value != '0) |-> done); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R9
endmodule

// File: rtl/shared_test_mem.sv
module shared_test_mem #(
  parameter int unsigned DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_valid,
  input  logic [31:0] fetch_addr,
  output logic [31:0] fetch_data,
  input  logic        data_valid,
  input  logic        data_wr,
  input  logic [31:0] data_addr,
  input  logic [31:0] data_wdata,
  output logic [31:0] data_rdata,
  input  logic        preload_we,
  input  logic [31:0] preload_addr,
  input  logic [31:0] preload_wdata,
  input  logic        mbox_we,
  input  logic [31:0] mbox_wdata,
  output logic [31:0] mbox_value,
  output logic        run_done
);
  localparam int unsigned IDX_W  = $clog2(DEPTH);
  localparam int unsigned NADDR  = 3;   // fetch, data, preload
  localparam int unsigned P_FET  = 0;
  localparam int unsigned P_DAT  = 1;
  localparam int unsigned P_PRE  = 2;

  stm_pkg::word_t   addr_vec [NADDR];
  logic [IDX_W-1:0] idx_vec  [NADDR];

  assign addr_vec[P_FET] = fetch_addr;
  assign addr_vec[P_DAT] = data_addr;
  assign addr_vec[P_PRE] = preload_addr;

  for (genvar p = 0; p < NADDR; p++) begin : g_idx
    stm_index #(.IDX_W(IDX_W)) u_idx (
      .byte_addr (addr_vec[p]),
      .word_idx  (idx_vec[p])
    );
  end

  logic             store_en;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  stm_pkg::word_t   wr_data;
  stm_pkg::word_t   fet_raw;
  stm_pkg::word_t   dat_raw;

  assign store_en = data_valid & data_wr;

  stm_wsel #(.IDX_W(IDX_W)) u_wsel (
    .st_en   (store_en),
    .st_idx  (idx_vec[P_DAT]),
    .st_data (data_wdata),
    .pl_en   (preload_we),
    .pl_idx  (idx_vec[P_PRE]),
    .pl_data (preload_wdata),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  stm_array #(.DEPTH(DEPTH)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_a_idx  (idx_vec[P_FET]),
    .rd_a_data (fet_raw),
    .rd_b_idx  (idx_vec[P_DAT]),
    .rd_b_data (dat_raw)
  );

  assign fetch_data = fetch_valid ? fet_raw : '0;
  assign data_rdata = (data_valid && !data_wr) ? dat_raw : '0;

  stm_mailbox u_mbox (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mbox_we),
    .wdata (mbox_wdata),
    .value (mbox_value),
    .done  (run_done)
  );

  AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |=> (!fetch_valid || idx_vec[P_FET] != $past(idx_vec[P_DAT])
                  || fetch_data == $past(data_wdata))); // R1
endmodule

// File: tb/shared_test_mem_test.sv
module shared_test_mem_test;
  localparam int unsigned DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic [31:0] fetch_data;
  logic        data_valid = 1'b0;
  logic        data_wr = 1'b0;
  logic [31:0] data_addr = '0;
  logic [31:0] data_wdata = '0;
  logic [31:0] data_rdata;
  logic        preload_we = 1'b0;
  logic [31:0] preload_addr = '0;
  logic [31:0] preload_wdata = '0;
  logic        mbox_we = 1'b0;
  logic [31:0] mbox_wdata = '0;
  logic [31:0] mbox_value;
  logic        run_done;

  shared_test_mem #(.DEPTH(DEPTH)) uut (.*);

  always #4 clk = ~clk; // 125 MHz

  typedef struct {
    int          sel;   // 0 fetch_data, 1 data_rdata, 2 mbox_value, 3 run_done
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  pushed;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;

  // Monitor: pops expected items and compares them against the ports.
  initial begin
    forever begin
      @(pushed);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        case (it.sel)
          0: got = fetch_data;
          1: got = data_rdata;
          2: got = mbox_value;
          default: got = {31'd0, run_done};
        endcase
        n_chk++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s: sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic expect_out(input int sel, input logic [31:0] exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
    -> pushed;
    #1;
  endtask

  task automatic idle();
    fetch_valid = 0; data_valid = 0; data_wr = 0; preload_we = 0; mbox_we = 0;
  endtask

  task automatic preload(input int w, input logic [31:0] v);
    @(negedge clk); idle();
    preload_we = 1; preload_addr = w * 4; preload_wdata = v;
  endtask

  task automatic fetch_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); idle();
    fetch_valid = 1; fetch_addr = a;
    #1 expect_out(0, exp, req);
  endtask

  localparam logic [31:0] VA = 32'hA5A5_0003;
  localparam logic [31:0] VC = 32'hC0DE_0007;
  localparam logic [31:0] VG = 32'h6666_000A;
  localparam logic [31:0] VB = 32'hB0B0_1234;
  localparam logic [31:0] VF = 32'hF00D_000B;

  initial begin
    repeat (3) @(negedge clk);
    expect_out(2, 32'd0, "R7 mailbox after reset");
    expect_out(3, 32'd0, "R7 done after reset");
    @(negedge clk); rst_n = 1;

    preload(3, VA);
    preload(7, VC);
    preload(10, VG);
    fetch_chk(32'd12, VA, "R10 preload then fetch, R4 combinational");
    fetch_chk(32'd15, VA, "R2 low bits ignored");
    fetch_chk((DEPTH + 3) * 4 + 1, VA, "R3 wrap above depth");
    @(negedge clk); idle(); fetch_addr = 32'd12;
    #1 expect_out(0, 32'd0, "R4 fetch idle gives zero");

    // Same-cycle store and fetch of word 7.
    @(negedge clk); idle();
    data_valid = 1; data_wr = 1; data_addr = 32'd29; data_wdata = VB;
    fetch_valid = 1; fetch_addr = 32'd28;
    #1 expect_out(0, VC, "R5 same-cycle fetch sees old word");
    expect_out(1, 32'd0, "R11 rdata zero during store");
    fetch_chk(32'd28, VB, "R1 store visible to later fetch");
    @(negedge clk); idle();
    data_valid = 1; data_addr = 32'd28;
    #1 expect_out(1, VB, "R4 load returns word");

    // Load with junk write data, then invalid store: array must hold.
    @(negedge clk); idle();
    data_valid = 1; data_wr = 0; data_addr = 32'd12; data_wdata = 32'hDEAD_BEEF;
    fetch_chk(32'd12, VA, "R6 load does not write");
    @(negedge clk); idle();
    data_valid = 0; data_wr = 1; data_addr = 32'd12; data_wdata = 32'hDEAD_BEEF;
    #1 expect_out(1, 32'd0, "R11 rdata zero when invalid");
    fetch_chk(32'd12, VA, "R6 invalid store does not write");

    // Store and preload in the same cycle: preload dropped.
    @(negedge clk); idle();
    data_valid = 1; data_wr = 1; data_addr = 32'd44; data_wdata = VF;
    preload_we = 1; preload_addr = 32'd40; preload_wdata = 32'h1111_1111;
    fetch_chk(32'd40, VG, "R10 preload dropped under store");
    fetch_chk(32'd44, VF, "R10 store wins");

    // Mailbox sequence.
    @(negedge clk); idle(); mbox_we = 1; mbox_wdata = 32'd0;
    @(negedge clk); idle();
    expect_out(3, 32'd0, "R8 zero code leaves done low");
    mbox_we = 1; mbox_wdata = 32'd5;
    #1 expect_out(3, 32'd0, "R8 done not before edge");
    @(negedge clk); idle();
    expect_out(2, 32'd5, "R8 mailbox loaded");
    expect_out(3, 32'd1, "R8 done with non-zero mailbox");
    mbox_we = 1; mbox_wdata = 32'd0;
    @(negedge clk); idle();
    expect_out(2, 32'd0, "R9 mailbox rewritten zero");
    expect_out(3, 32'd1, "R9 done sticky");

    // Reset clears mailbox/done but not the array.
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    expect_out(3, 32'd0, "R7 done cleared by reset");
    fetch_chk(32'd12, VA, "R7 array kept through reset");
    fetch_chk(32'd28, VB, "R7 stored word kept through reset");

    @(negedge clk); idle();
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    #2;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule